// File: doc/BRIEF.md
# Fringe Profile Detrend and Correlation Unit

This block takes one line of camera pixels that crosses a set of interference fringes and reduces it to three numbers. These are the fringe amplitude and two projections of the fringe onto a sine and a cosine reference. A downstream phase search uses those numbers. The pixels arrive as a short burst of signed intensities. The block buffers them and removes the tilt of the illuminated surface with a straight-line least-squares fit. It then measures half the peak-to-peak span of what remains, and correlates the flattened samples against two per-index coefficient tables.

The block contains no divider. The mean of the intensities and the fitted slope both come from a multiply by a reciprocal that is fixed at elaboration time, followed by an arithmetic right shift. The pixel index is kept doubled and centred (2i−(M−1)), so its mean is exactly zero for any profile length. The coefficient tables are filled through a write port before any profile that uses them.

Top module: `lsq_fringe_core`

## Requirements
- R1: After reset, busy_o and done_o are low, and amp_o, sum_sin_o and sum_cos_o are zero.
- R2: A start_i pulse seen while idle opens a load phase. The next M cycles with pix_valid_i high store pixels for indices 0, 1, …, M−1 in that order. pix_valid_i outside a load phase has no effect on any result.
- R3: The profile mean is mu = floor(S·floor(2^24/M) / 2^24), where S is the sum of the M pixels.
- R4: The slope, with SLOPE_FRAC fraction bits, is q = floor(C·floor(2^24/V) / 2^(23−SLOPE_FRAC)), saturated to SLOPE_W signed bits. Here C = Σ(2i−M+1)·p[i] and V = M(M²−1)/3.
- R5: Each corrected sample is c[i] = p[i] − mu − floor(q·(2i−M+1) / 2^(SLOPE_FRAC+1)), saturated to CORR_W signed bits.
- R6: amp_o = floor((max c − min c)/2).
- R7: sum_sin_o = Σ c[i]·ks[i] and sum_cos_o = Σ c[i]·kc[i]. ks[i] and kc[i] are the signed entries last written to index i when coef_we_i was high at a clock edge.
- R8: done_o is high for exactly one cycle, 2M+3 clock edges after the edge that accepts the last pixel. The three result outputs change only in that cycle and hold their values until the next done_o.
- R9: start_i and pix_valid_i have no effect while busy_o is high. A profile in progress finishes with its own data and its normal latency.
- R10: busy_o is high from the edge that accepts start_i until the result is published, and it is low in the cycle that done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new profile (idle only) |
| pix_valid_i | input | 1 | Pixel strobe during load |
| pix_i | input | PIX_W | Signed pixel intensity |
| coef_we_i | input | 1 | Coefficient table write enable |
| coef_idx_i | input | IDX_W | Coefficient table index |
| coef_sin_i | input | COEF_W | Signed sine-table entry |
| coef_cos_i | input | COEF_W | Signed cosine-table entry |
| busy_o | output | 1 | Profile being loaded or processed |
| done_o | output | 1 | One-cycle result strobe |
| amp_o | output | CORR_W | Half peak-to-peak of corrected samples |
| sum_sin_o | output | ACC_W | Sine-weighted sum of corrected samples |
| sum_cos_o | output | ACC_W | Cosine-weighted sum of corrected samples |

## Verification
The embedded assertions check the control-side rules on every cycle. They cover the single-cycle done strobe, that busy is low while done is high, that the results stay frozen between strobes, that the buffer index stays in range, that a start during computation does not restart loading, and that the running maximum never falls below the running minimum. The arithmetic cannot be shown cycle by cycle: the mean, the slope, the saturated detrend, the amplitude and the two correlation sums only become visible at the outputs once a profile is complete. The bench covers them with flat, ramped, fringe-plus-tilt and random profiles over two coefficient table sets, each compared against an integer model. It also covers the exact done latency and start or pixel pulses injected while the block is busy.

// File: rtl/lsq_fringe_pkg.sv
package lsq_fringe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MEAN,
    ST_COV,
    ST_SLOPE,
    ST_DET,
    ST_FIN
  } state_e;

  localparam int RCP_SH = 24;
  localparam int RCP_W  = 26;
endpackage

// File: rtl/lsq_coef_tables.sv
module lsq_coef_tables #(
  parameter int NPIX   = 20,
  parameter int COEF_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         waddr_i,
  input  logic signed [COEF_W-1:0] wsin_i,
  input  logic signed [COEF_W-1:0] wcos_i,
  input  logic [IDX_W-1:0]         raddr_i,
  output logic signed [COEF_W-1:0] sin_o,
  output logic signed [COEF_W-1:0] cos_o
);
  logic signed [COEF_W-1:0] sin_q [NPIX];
  logic signed [COEF_W-1:0] cos_q [NPIX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NPIX; k++) begin
        sin_q[k] <= '0;
        cos_q[k] <= '0;
      end
    end else if (we_i && (int'(waddr_i) < NPIX)) begin
      sin_q[waddr_i] <= wsin_i;
      cos_q[waddr_i] <= wcos_i;
    end
  end

  assign sin_o = sin_q[raddr_i];
  assign cos_o = cos_q[raddr_i];
endmodule

// File: rtl/lsq_profile_buf.sv
module lsq_profile_buf #(
  parameter int NPIX  = 20,
  parameter int PIX_W = 12,
  parameter int IDX_W = 5
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        waddr_i,
  input  logic signed [PIX_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]        raddr_i,
  output logic signed [PIX_W-1:0] rdata_o
);
  logic signed [PIX_W-1:0] mem_q [NPIX];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lsq_detrend_corr.sv
module lsq_detrend_corr #(
  parameter int PIX_W      = 12,
  parameter int COEF_W     = 16,
  parameter int SLOPE_W    = 18,
  parameter int SLOPE_FRAC = 6,
  parameter int X2_W       = 7,
  parameter int CORR_W     = 15,
  parameter int ACC_W      = 37
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      en_i,
  input  logic signed [PIX_W-1:0]   pix_i,
  input  logic signed [PIX_W-1:0]   mean_i,
  input  logic signed [SLOPE_W-1:0] slope_i,
  input  logic signed [X2_W-1:0]    x2_i,
  input  logic signed [COEF_W-1:0]  sin_i,
  input  logic signed [COEF_W-1:0]  cos_i,
  output logic signed [CORR_W-1:0]  max_o,
  output logic signed [CORR_W-1:0]  min_o,
  output logic signed [ACC_W-1:0]   acc_sin_o,
  output logic signed [ACC_W-1:0]   acc_cos_o
);
  localparam int TR_W = SLOPE_W + X2_W;
  localparam int DW   = TR_W + PIX_W;
  localparam int PW   = CORR_W + COEF_W;
  localparam logic signed [DW-1:0] C_HI = DW'((longint'(1) <<< (CORR_W-1)) - 1);
  localparam logic signed [DW-1:0] C_LO = DW'(-(longint'(1) <<< (CORR_W-1)));
  localparam logic signed [CORR_W-1:0] C_HI_N = C_HI[CORR_W-1:0];
  localparam logic signed [CORR_W-1:0] C_LO_N = C_LO[CORR_W-1:0];

  logic signed [TR_W-1:0]   trend_full, trend;
  logic signed [DW-1:0]     diff;
  logic signed [CORR_W-1:0] corr;
  logic signed [PW-1:0]     prod_s, prod_c;
  logic signed [CORR_W-1:0] max_q, min_q;
  logic signed [ACC_W-1:0]  acc_s_q, acc_c_q;

  assign trend_full = slope_i * x2_i;
  assign trend      = trend_full >>> (SLOPE_FRAC + 1);
  assign diff       = DW'(pix_i) - DW'(mean_i) - DW'(trend);
  assign corr       = (diff > C_HI) ? C_HI_N :
                      (diff < C_LO) ? C_LO_N : diff[CORR_W-1:0];
  assign prod_s     = corr * sin_i;
  assign prod_c     = corr * cos_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q   <= C_LO_N;
      min_q   <= C_HI_N;
      acc_s_q <= '0;
      acc_c_q <= '0;
    end else if (clr_i) begin
      max_q   <= C_LO_N;
      min_q   <= C_HI_N;
      acc_s_q <= '0;
      acc_c_q <= '0;
    end else if (en_i) begin
      if (corr > max_q) max_q <= corr;
      if (corr < min_q) min_q <= corr;
      acc_s_q <= acc_s_q + ACC_W'(prod_s);
      acc_c_q <= acc_c_q + ACC_W'(prod_c);
    end
  end

  assign max_o     = max_q;
  assign min_o     = min_q;
  assign acc_sin_o = acc_s_q;
  assign acc_cos_o = acc_c_q;

  AST_SPAN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) && !$past(clr_i) |-> max_q >= min_q); // R6
endmodule

// File: rtl/lsq_fringe_core.sv
module lsq_fringe_core
  import lsq_fringe_pkg::*;
#(
  parameter int NPIX       = 20,
  parameter int PIX_W      = 12,
  parameter int COEF_W     = 16,
  parameter int SLOPE_W    = 18,
  parameter int SLOPE_FRAC = 6,
  parameter int CORR_W     = 15,
  parameter int IDX_W      = $clog2(NPIX),
  parameter int ACC_W      = CORR_W + COEF_W + $clog2(NPIX) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     pix_valid_i,
  input  logic signed [PIX_W-1:0]  pix_i,
  input  logic                     coef_we_i,
  input  logic [IDX_W-1:0]         coef_idx_i,
  input  logic signed [COEF_W-1:0] coef_sin_i,
  input  logic signed [COEF_W-1:0] coef_cos_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic signed [CORR_W-1:0] amp_o,
  output logic signed [ACC_W-1:0]  sum_sin_o,
  output logic signed [ACC_W-1:0]  sum_cos_o
);
  localparam int X2_W   = IDX_W + 2;
  localparam int SUM_W  = PIX_W + $clog2(NPIX) + 1;
  localparam int COV_W  = PIX_W + X2_W + $clog2(NPIX) + 1;
  localparam int MP_W   = SUM_W + RCP_W;
  localparam int SP_W   = COV_W + RCP_W;
  localparam int SL_SH  = RCP_SH - 1 - SLOPE_FRAC;
  localparam longint VAR2 = longint'(NPIX) * (longint'(NPIX) * NPIX - 1) / 3;
  localparam logic signed [RCP_W-1:0] MEAN_RCP = RCP_W'((longint'(1) << RCP_SH) / NPIX);
  localparam logic signed [RCP_W-1:0] VAR_RCP  = RCP_W'((longint'(1) << RCP_SH) / VAR2);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);
  localparam logic signed [SP_W-1:0] S_HI = SP_W'((longint'(1) <<< (SLOPE_W-1)) - 1);
  localparam logic signed [SP_W-1:0] S_LO = SP_W'(-(longint'(1) <<< (SLOPE_W-1)));

  state_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic signed [SUM_W-1:0] sum_q;
  logic signed [COV_W-1:0] cov_q;
  logic signed [PIX_W-1:0] mean_q, buf_rd, mean_d;
  logic signed [SLOPE_W-1:0] slope_q, slope_d;
  logic signed [X2_W-1:0] x2;
  logic signed [MP_W-1:0] mean_prod, mean_sh;
  logic signed [SP_W-1:0] sl_prod, sl_sh;
  logic signed [X2_W+PIX_W-1:0] cov_prod;
  logic signed [COEF_W-1:0] k_sin, k_cos;
  logic signed [CORR_W-1:0] run_max, run_min;
  logic signed [CORR_W:0] span;
  logic signed [ACC_W-1:0] acc_s, acc_c;
  logic signed [CORR_W-1:0] amp_q;
  logic signed [ACC_W-1:0] sum_s_q, sum_c_q;
  logic done_q, buf_we, det_clr, det_en;

  assign buf_we  = (state_q == ST_LOAD) && pix_valid_i;
  assign det_clr = (state_q == ST_SLOPE);
  assign det_en  = (state_q == ST_DET);

  lsq_profile_buf #(.NPIX(NPIX), .PIX_W(PIX_W), .IDX_W(IDX_W)) u_buf (
    .clk_i(clk_i), .we_i(buf_we), .waddr_i(idx_q), .wdata_i(pix_i),
    .raddr_i(idx_q), .rdata_o(buf_rd));

  lsq_coef_tables #(.NPIX(NPIX), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_coef (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(coef_we_i), .waddr_i(coef_idx_i),
    .wsin_i(coef_sin_i), .wcos_i(coef_cos_i), .raddr_i(idx_q),
    .sin_o(k_sin), .cos_o(k_cos));

  // doubled, centred index: 2i-(M-1), exact zero mean
  assign x2 = $signed({1'b0, idx_q, 1'b0}) - X2_W'(NPIX - 1);

  assign mean_prod = sum_q * MEAN_RCP;
  assign mean_sh   = mean_prod >>> RCP_SH;
  assign mean_d    = mean_sh[PIX_W-1:0];

  assign cov_prod  = x2 * buf_rd;

  assign sl_prod   = cov_q * VAR_RCP;
  assign sl_sh     = sl_prod >>> SL_SH;
  assign slope_d   = (sl_sh > S_HI) ? S_HI[SLOPE_W-1:0] :
                     (sl_sh < S_LO) ? S_LO[SLOPE_W-1:0] : sl_sh[SLOPE_W-1:0];

  lsq_detrend_corr #(
    .PIX_W(PIX_W), .COEF_W(COEF_W), .SLOPE_W(SLOPE_W), .SLOPE_FRAC(SLOPE_FRAC),
    .X2_W(X2_W), .CORR_W(CORR_W), .ACC_W(ACC_W)
  ) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(det_clr), .en_i(det_en),
    .pix_i(buf_rd), .mean_i(mean_q), .slope_i(slope_q), .x2_i(x2),
    .sin_i(k_sin), .cos_i(k_cos), .max_o(run_max), .min_o(run_min),
    .acc_sin_o(acc_s), .acc_cos_o(acc_c));

  assign span = (CORR_W+1)'(run_max) - (CORR_W+1)'(run_min);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sum_q   <= '0;
      cov_q   <= '0;
      mean_q  <= '0;
      slope_q <= '0;
      amp_q   <= '0;
      sum_s_q <= '0;
      sum_c_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LOAD;
          idx_q   <= '0;
          sum_q   <= '0;
        end
        ST_LOAD: if (pix_valid_i) begin
          sum_q <= sum_q + SUM_W'(pix_i);
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= ST_MEAN;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_MEAN: begin
          mean_q  <= mean_d;
          cov_q   <= '0;
          state_q <= ST_COV;
        end
        ST_COV: begin
          cov_q <= cov_q + COV_W'(cov_prod);
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= ST_SLOPE;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_SLOPE: begin
          slope_q <= slope_d;
          state_q <= ST_DET;
        end
        ST_DET: begin
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= ST_FIN;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_FIN: begin
          amp_q   <= span[CORR_W:1];
          sum_s_q <= acc_s;
          sum_c_q <= acc_c;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign amp_o     = amp_q;
  assign sum_sin_o = sum_s_q;
  assign sum_cos_o = sum_c_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(amp_o) && $stable(sum_sin_o) && $stable(sum_cos_o)) |-> done_o); // R8
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < NPIX); // R2
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COV) && start_i |=> state_q != ST_LOAD); // R9
endmodule

// File: tb/lsq_fringe_core_tb_top.sv
`timescale 1ns/1ps
module lsq_fringe_core_tb_top;
  localparam int NPIX = 20, PIX_W = 12, COEF_W = 16, SLOPE_W = 18, SLOPE_FRAC = 6, CORR_W = 15;
  localparam int IDX_W = $clog2(NPIX);
  localparam int ACC_W = CORR_W + COEF_W + $clog2(NPIX) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, pvld = 1'b0, cwe = 1'b0;
  logic signed [PIX_W-1:0] pix = '0;
  logic [IDX_W-1:0] cidx = '0;
  logic signed [COEF_W-1:0] csin = '0, ccos = '0;
  logic busy, done;
  logic signed [CORR_W-1:0] amp;
  logic signed [ACC_W-1:0] ssin, scos;

  int checks = 0, errs = 0;
  longint parr [NPIX];
  longint ks [NPIX];
  longint kc [NPIX];

  always #4 clk = ~clk;

  lsq_fringe_core #(.NPIX(NPIX), .PIX_W(PIX_W), .COEF_W(COEF_W), .SLOPE_W(SLOPE_W),
    .SLOPE_FRAC(SLOPE_FRAC), .CORR_W(CORR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pix_valid_i(pvld), .pix_i(pix),
    .coef_we_i(cwe), .coef_idx_i(cidx), .coef_sin_i(csin), .coef_cos_i(ccos),
    .busy_o(busy), .done_o(done), .amp_o(amp), .sum_sin_o(ssin), .sum_cos_o(scos));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint satv(longint v, int n);
    longint hi = (longint'(1) <<< (n - 1)) - 1;
    longint lo = -hi - 1;
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  task automatic model(output longint e_amp, output longint e_s, output longint e_c);
    longint sum = 0, cov = 0, mu, v2, q, mx, mn;
    for (int i = 0; i < NPIX; i++) begin
      sum += parr[i];
      cov += longint'(2 * i - NPIX + 1) * parr[i];
    end
    mu = (sum * ((longint'(1) << 24) / NPIX)) >>> 24;                 // R3
    v2 = longint'(NPIX) * (NPIX * NPIX - 1) / 3;
    q  = satv((cov * ((longint'(1) << 24) / v2)) >>> (23 - SLOPE_FRAC), SLOPE_W); // R4
    mx = -(longint'(1) << 40); mn = longint'(1) << 40;
    e_s = 0; e_c = 0;
    for (int i = 0; i < NPIX; i++) begin
      longint tr = (q * (2 * i - NPIX + 1)) >>> (SLOPE_FRAC + 1);
      longint c  = satv(parr[i] - mu - tr, CORR_W);                  // R5
      if (c > mx) mx = c;
      if (c < mn) mn = c;
      e_s += c * ks[i];
      e_c += c * kc[i];
    end
    e_amp = (mx - mn) >>> 1;                                          // R6
  endtask

  task automatic load_tables();
    for (int i = 0; i < NPIX; i++) begin
      cwe = 1'b1; cidx = IDX_W'(i);
      csin = COEF_W'(ks[i]); ccos = COEF_W'(kc[i]);
      @(negedge clk);
    end
    cwe = 1'b0;
  endtask

  task automatic run(string tag, bit disturb);
    longint e_amp, e_s, e_c, h_amp, h_s, h_c;
    int cyc;
    bit seen_busy;
    model(e_amp, e_s, e_c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < NPIX; i++) begin
      pvld = 1'b1; pix = PIX_W'(parr[i]);
      @(negedge clk);
    end
    pvld = 1'b0;
    cyc = 1; seen_busy = 1'b0;
    while (!done && cyc < 300) begin
      if (cyc == 2) seen_busy = busy;
      if (disturb && cyc < 6) begin
        start = 1'b1; pvld = 1'b1; pix = PIX_W'(cyc * 311 - 1000);
      end else begin
        start = 1'b0; pvld = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; pvld = 1'b0;
    chk({"R10 busy during compute ", tag}, seen_busy, 1);
    chk({"R8 latency ", tag}, cyc - 1, 2 * NPIX + 3);
    chk({"R10 busy low at done ", tag}, busy, 0);
    chk({"R3 R4 R5 R6 amp ", tag}, amp, e_amp);
    chk({"R7 sine sum ", tag}, ssin, e_s);
    chk({"R7 cosine sum ", tag}, scos, e_c);
    h_amp = amp; h_s = ssin; h_c = scos;
    @(negedge clk);
    chk({"R8 single pulse ", tag}, done, 0);
    repeat (4) @(negedge clk);
    chk({"R8 hold amp ", tag}, amp, h_amp);
    chk({"R8 hold sums ", tag}, ssin + scos, h_s + h_c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 amp", amp, 0);
    chk("R1 sums", ssin | scos, 0);

    for (int i = 0; i < NPIX; i++) begin
      ks[i] = longint'($rtoi(16000.0 * $sin(6.2831853 * i / 5.3)));
      kc[i] = longint'($rtoi(16000.0 * $cos(6.2831853 * i / 5.3)));
    end
    load_tables();

    // R2: strobes while idle must not leak into the next profile
    for (int i = 0; i < 3; i++) begin
      pvld = 1'b1; pix = PIX_W'(1500 - i);
      @(negedge clk);
    end
    pvld = 1'b0;

    for (int i = 0; i < NPIX; i++) parr[i] = 0;
    run("R2 zeros", 0);
    for (int i = 0; i < NPIX; i++) parr[i] = 1000;
    run("flat", 0);
    for (int i = 0; i < NPIX; i++) parr[i] = 50 * i - 500;
    run("ramp", 0);
    for (int i = 0; i < NPIX; i++) parr[i] = (i < NPIX / 2) ? -2048 : 2047;
    run("step extremes", 0);
    for (int ph = 0; ph < 8; ph++) begin
      for (int i = 0; i < NPIX; i++)
        parr[i] = longint'($rtoi(700.0 * $cos(6.2831853 * i / 5.3 + 0.785 * ph))) + 30 * i - 300;
      run("fringe+tilt", ph == 3);
    end
    for (int r = 0; r < 12; r++) begin
      for (int i = 0; i < NPIX; i++) parr[i] = longint'($urandom_range(4095)) - 2048;
      run("random", r == 5);
    end

    // R7: new tables change the sums for the same profile
    for (int i = 0; i < NPIX; i++) begin
      ks[i] = 100 * i - 900;
      kc[i] = (i % 2 == 0) ? 32767 : -32768;
    end
    load_tables();
    for (int i = 0; i < NPIX; i++)
      parr[i] = longint'($rtoi(900.0 * $sin(6.2831853 * i / 4.1))) - 20 * i;
    run("R7 second tables", 0);
    for (int i = 0; i < NPIX; i++) parr[i] = longint'($urandom_range(4095)) - 2048;
    run("R9 disturbed", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule